// File: doc/BRIEF.md
# Dual-Channel Safety Comparator Supervisor

This block watches two redundant controller channels that compute the same output word, and lets that word reach the actuator only while both channels agree. After every reset it runs a known-answer test before the actuator is enabled. It drives a select line that steers a fixed sequence of test stimuli into both channels. It reports which pattern is in use and checks each pair of responses against an expected value that it computes itself.

When every pattern has passed, the supervisor enters run mode. In run mode it compares the two results on each cycle in which both channels flag their result as valid. An agreeing pair is passed to the actuator register. A disagreement, a failed test answer, or a channel that stops producing valid results causes a trip. A trip raises the interrupt, forces the actuator word to zero and records a cause code. The tripped state holds until an explicit clear is given, and the clear always leads into a fresh self-test rather than straight back to run mode.

The reset input is asserted asynchronously and released through a local two-stage synchronizer. The design clock is 50 MHz.

Top module: `dual_chan_supervisor`

## Requirements
- R1: While reset is low, and in the cycles just after its release, `act_out` is 0, `irq` is 0, `tst_sel` is 0 and `trip_code` is 0. Three rising edges after `rst_n` goes high, the block is in self-test and `tst_sel` is 1.
- R2: In self-test, `tst_sel` is 1 and `act_out` is 0. `tst_idx` starts at 0 and advances by one on each cycle in which both valid strobes are high and both results equal the expected word for the current index. The expected word is (SEED + i*STEP) mod 2^DW, which is 12'h3A5 + i*12'h2C7 with the default parameters.
- R3: When the pair for the last index (NPAT-1) matches, the block enters run mode on that edge, and `tst_sel` returns to 0.
- R4: In self-test, if both strobes are high and either result differs from the expected word, the block trips with `trip_code` = 1.
- R5: In run mode, when both strobes are high and the results are equal, `act_out` takes that value on the next edge. When only one strobe, or neither, is high, `act_out` holds its value.
- R6: In run mode, when both strobes are high and the results differ, the block trips with `trip_code` = 2. After that edge `irq` is 1 and `act_out` is 0.
- R7: In self-test or run mode, TMO consecutive cycles (default 8) without both strobes high cause a trip with `trip_code` = 3. A gap of TMO-1 cycles followed by a joint strobe does not trip.
- R8: Once tripped, `irq` stays 1, `act_out` stays 0 and `trip_code` keeps its value, whatever the channel inputs are, until a clear is given. `safe_clr` has no effect in run mode.
- R9: `safe_clr` high in the tripped state starts a new self-test from index 0 on the next edge, with `irq` 0 and `trip_code` 0.
- R10: Pulling `rst_n` low at any time returns all outputs to their reset values at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 50 MHz clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_a_res | input | DW | Result word of channel A |
| ch_a_vld | input | 1 | Channel A result valid |
| ch_b_res | input | DW | Result word of channel B |
| ch_b_vld | input | 1 | Channel B result valid |
| safe_clr | input | 1 | Leave the tripped state and restart self-test |
| act_out | output | DW | Gated actuator word, 0 unless in run mode |
| irq | output | 1 | High while tripped |
| tst_sel | output | 1 | Steers test stimuli into both channels during self-test |
| tst_idx | output | max(1,clog2(NPAT)) | Index of the test pattern being applied |
| trip_code | output | 2 | Trip cause: 0 none, 1 self-test, 2 runtime mismatch, 3 timeout |

## Verification
Several properties are checked on every cycle. A runtime disagreement must lead to `irq` high and a dark actuator one edge later. The actuator must stay at zero whenever `tst_sel` or `irq` is high. An agreeing pair must appear on `act_out`. The tripped state and its code must persist until a clear, and the timeout counter and pattern index must stay inside their ranges. Other behaviour can only be shown by the bench's scenarios. This covers the exact pattern sequence and the expected-value formula, and the exact boundary between TMO-1 and TMO idle cycles. It also covers the order of entry into run mode and the full round trip through clear and a repeated self-test, as well as a reset pulled in the middle of a cycle.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_RESET    = 2'd0,
    ST_SELFTEST = 2'd1,
    ST_RUN      = 2'd2,
    ST_SAFE     = 2'd3
  } sup_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_SELFTEST = 2'd1,
    CAUSE_RUNTIME  = 2'd2,
    CAUSE_TIMEOUT  = 2'd3
  } trip_cause_e;

  function automatic int idx_w(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sup_rst_sync.sv
module sup_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sn = sh_q[STAGES-1];
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int TMO = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic beat,
  output logic expire
);
  localparam int CW = $clog2(TMO + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    expire = armed && !beat && (cnt_q == CW'(TMO - 1));
    cnt_en = armed || (cnt_q != '0);
    if (!armed || beat || expire) cnt_d = '0;
    else                          cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R7: the idle counter never passes the trip limit
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TMO - 1));
endmodule

// File: rtl/sup_selftest.sv
module sup_selftest #(
  parameter int          DW   = 12,
  parameter int          NPAT = 4,
  parameter logic [DW-1:0] SEED = 12'h3A5,
  parameter logic [DW-1:0] STEP = 12'h2C7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               both_vld,
  input  logic [DW-1:0]      res_a,
  input  logic [DW-1:0]      res_b,
  output logic [sup_pkg::idx_w(NPAT)-1:0] idx,
  output logic               pass_all,
  output logic               fail
);
  localparam int IW = sup_pkg::idx_w(NPAT);

  function automatic logic [DW-1:0] exp_of(logic [IW-1:0] i);
    return SEED + STEP * DW'(i);
  endfunction

  logic [IW-1:0] idx_q, idx_d;
  logic [DW-1:0] exp_w;
  logic          hit, good, last, idx_en;

  always_comb begin
    exp_w    = exp_of(idx_q);
    hit      = active && both_vld;
    good     = (res_a == exp_w) && (res_b == exp_w);
    last     = (idx_q == IW'(NPAT - 1));
    fail     = hit && !good;
    pass_all = hit && good && last;
    idx_en   = !active || (hit && good && !last);
    idx_d    = active ? idx_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign idx = idx_q;

  // R2: the pattern index stays within the pattern table
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(NPAT - 1));
  // R2: a pattern answered correctly moves the index forward
  p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && good && !last) |=> (idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/dual_chan_supervisor.sv
module dual_chan_supervisor
  import sup_pkg::*;
#(
  parameter int            DW         = 12,
  parameter int            NPAT       = 4,
  parameter int            TMO        = 8,
  parameter logic [DW-1:0] SEED       = 12'h3A5,
  parameter logic [DW-1:0] STEP       = 12'h2C7,
  parameter int            RST_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [DW-1:0]             ch_a_res,
  input  logic                      ch_a_vld,
  input  logic [DW-1:0]             ch_b_res,
  input  logic                      ch_b_vld,
  input  logic                      safe_clr,
  output logic [DW-1:0]             act_out,
  output logic                      irq,
  output logic                      tst_sel,
  output logic [idx_w(NPAT)-1:0]    tst_idx,
  output logic [1:0]                trip_code
);
  logic          rst_sn;
  sup_state_e    state_q, state_d;
  trip_cause_e   cause_q, cause_d;
  logic [DW-1:0] act_q, act_d;
  logic          both_vld, agree, expire, st_pass, st_fail;
  logic          state_en, cause_en, act_en;

  sup_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_an(rst_n), .rst_sn(rst_sn)
  );

  assign both_vld = ch_a_vld && ch_b_vld;
  assign agree    = (ch_a_res == ch_b_res);

  sup_wdog #(.TMO(TMO)) u_wdog (
    .clk(clk), .rst_n(rst_sn),
    .armed(state_q == ST_SELFTEST || state_q == ST_RUN),
    .beat(both_vld), .expire(expire)
  );

  sup_selftest #(.DW(DW), .NPAT(NPAT), .SEED(SEED), .STEP(STEP)) u_st (
    .clk(clk), .rst_n(rst_sn), .active(state_q == ST_SELFTEST),
    .both_vld(both_vld), .res_a(ch_a_res), .res_b(ch_b_res),
    .idx(tst_idx), .pass_all(st_pass), .fail(st_fail)
  );

  // next state
  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      ST_RESET: state_d = ST_SELFTEST;
      ST_SELFTEST: begin
        if (expire) begin
          state_d = ST_SAFE; cause_d = CAUSE_TIMEOUT;
        end else if (st_fail) begin
          state_d = ST_SAFE; cause_d = CAUSE_SELFTEST;
        end else if (st_pass) begin
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (expire) begin
          state_d = ST_SAFE; cause_d = CAUSE_TIMEOUT;
        end else if (both_vld && !agree) begin
          state_d = ST_SAFE; cause_d = CAUSE_RUNTIME;
        end
      end
      ST_SAFE: begin
        if (safe_clr) begin
          state_d = ST_SELFTEST; cause_d = CAUSE_NONE;
        end
      end
      default: state_d = ST_RESET;
    endcase

    if (state_q == ST_RUN && state_d == ST_RUN)
      act_d = (both_vld && agree) ? ch_a_res : act_q;
    else
      act_d = '0;

    state_en = (state_d != state_q);
    cause_en = (cause_d != cause_q);
    act_en   = (act_d != act_q);
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_RESET;
      cause_q <= CAUSE_NONE;
      act_q   <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (cause_en) cause_q <= cause_d;
      if (act_en)   act_q   <= act_d;
    end
  end

  assign act_out   = act_q;
  assign irq       = (state_q == ST_SAFE);
  assign tst_sel   = (state_q == ST_SELFTEST);
  assign trip_code = cause_q;

  // R6: a runtime disagreement trips and darkens the actuator next cycle
  p_trip_off_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_RUN && both_vld && !agree) |=>
      (irq && act_out == '0 && trip_code == 2'd2));
  // R5: an agreeing pair in run mode reaches the actuator
  p_follow_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_RUN && both_vld && agree) |=> (act_out == $past(ch_a_res)));
  // R2: actuator is dark during self-test
  p_test_dark_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    tst_sel |-> (act_out == '0));
  // R8: actuator is dark while tripped, and the trip is sticky
  p_safe_dark_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    irq |-> (act_out == '0));
  p_safe_sticky_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq && !safe_clr) |=> (irq && $stable(trip_code)));
  // R9: a clear leads into a fresh self-test
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq && safe_clr) |=> (tst_sel && !irq && trip_code == 2'd0 && tst_idx == '0));
  // R1: at most one of self-test and tripped is shown
  p_mode_excl_r1: assert property (@(posedge clk) disable iff (!rst_sn)
    !(tst_sel && irq));
endmodule

// File: tb/dual_chan_supervisor_test.sv
module dual_chan_supervisor_test;
  localparam int DW = 12;
  localparam int NPAT = 4;
  localparam int TMO = 8;
  localparam logic [DW-1:0] SEED = 12'h3A5;
  localparam logic [DW-1:0] STEP = 12'h2C7;

  // run-mode vectors: {va, vb, a, b, expected act_out, expected irq}
  localparam int NV = 8;
  localparam logic [38:0] VEC [NV] = '{
    {1'b1, 1'b1, 12'h100, 12'h100, 12'h100, 1'b0},
    {1'b1, 1'b0, 12'h200, 12'h300, 12'h100, 1'b0},
    {1'b0, 1'b1, 12'h400, 12'h400, 12'h100, 1'b0},
    {1'b1, 1'b1, 12'h7FF, 12'h7FF, 12'h7FF, 1'b0},
    {1'b1, 1'b1, 12'hFFF, 12'hFFF, 12'hFFF, 1'b0},
    {1'b1, 1'b1, 12'h000, 12'h000, 12'h000, 1'b0},
    {1'b1, 1'b1, 12'h0AB, 12'h0AB, 12'h0AB, 1'b0},
    {1'b1, 1'b1, 12'h123, 12'h124, 12'h000, 1'b1}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [DW-1:0] a_res, b_res;
  logic          a_vld, b_vld, clr;
  logic [DW-1:0] act_out;
  logic          irq, tst_sel;
  logic [1:0]    tst_idx;
  logic [1:0]    trip_code;

  int checks = 0;
  int fails  = 0;

  dual_chan_supervisor uut (
    .clk(clk), .rst_n(rst_n),
    .ch_a_res(a_res), .ch_a_vld(a_vld),
    .ch_b_res(b_res), .ch_b_vld(b_vld),
    .safe_clr(clr),
    .act_out(act_out), .irq(irq), .tst_sel(tst_sel),
    .tst_idx(tst_idx), .trip_code(trip_code)
  );

  function automatic logic [DW-1:0] expv(int i);
    return SEED + STEP * DW'(i);
  endfunction

  task automatic chk(string what, logic [31:0] actual, logic [31:0] expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, actual, expected);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(logic va, logic [DW-1:0] a, logic vb, logic [DW-1:0] b);
    a_vld = va; a_res = a; b_vld = vb; b_res = b;
  endtask

  // drives the self-test answers; bad >= 0 corrupts channel B at that index
  task automatic run_st(int bad);
    for (int k = 0; k < NPAT; k++) begin
      chk("R2 tst_sel", tst_sel, 1);
      chk("R2 tst_idx", tst_idx, k);
      chk("R2 act_out dark", act_out, 0);
      drive(1'b1, expv(k), 1'b1, (k == bad) ? expv(k) ^ 12'h001 : expv(k));
      step();
      if (k == bad) begin
        chk("R4 irq", irq, 1);
        chk("R4 trip_code", trip_code, 1);
        chk("R4 act_out", act_out, 0);
        break;
      end
    end
    if (bad < 0) begin
      chk("R3 tst_sel low in run", tst_sel, 0);
      chk("R3 irq low in run", irq, 0);
    end
    drive(1'b0, '0, 1'b0, '0);
  endtask

  task automatic do_clear();
    clr = 1'b1;
    step();
    clr = 1'b0;
    chk("R9 tst_sel", tst_sel, 1);
    chk("R9 tst_idx", tst_idx, 0);
    chk("R9 irq", irq, 0);
    chk("R9 trip_code", trip_code, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0;
    drive(1'b0, '0, 1'b0, '0);
    step(); step();
    // R1: reset values
    chk("R1 act_out", act_out, 0);
    chk("R1 irq", irq, 0);
    chk("R1 tst_sel", tst_sel, 0);
    chk("R1 trip_code", trip_code, 0);
    rst_n = 1'b1;
    step(); step();
    chk("R1 still idle after sync", tst_sel, 0);
    step();
    chk("R1 self-test entered", tst_sel, 1);

    // R2, R3: passing self-test
    run_st(-1);

    // R5, R6: table walk in run mode
    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][38], VEC[v][36:25], VEC[v][37], VEC[v][24:13]);
      step();
      chk("R5 act_out vector", act_out, VEC[v][12:1]);
      chk("R6 irq vector", irq, VEC[v][0]);
    end
    chk("R6 trip_code runtime", trip_code, 2);

    // R8: sticky safe state with agreeing inputs
    for (int n = 0; n < 3; n++) begin
      drive(1'b1, 12'h555, 1'b1, 12'h555);
      step();
      chk("R8 irq sticky", irq, 1);
      chk("R8 act_out dark", act_out, 0);
      chk("R8 trip_code kept", trip_code, 2);
    end
    drive(1'b0, '0, 1'b0, '0);

    // R9 then R4: clear, failing self-test at index 2
    do_clear();
    run_st(2);

    // R9, R3: clear, passing self-test, clear ignored in run
    do_clear();
    run_st(-1);
    clr = 1'b1;
    drive(1'b1, 12'h321, 1'b1, 12'h321);
    step();
    clr = 1'b0;
    chk("R8 clear ignored in run tst_sel", tst_sel, 0);
    chk("R8 clear ignored in run act_out", act_out, 12'h321);

    // R7: gap of TMO-1 idle cycles does not trip
    drive(1'b0, '0, 1'b0, '0);
    for (int n = 0; n < TMO - 1; n++) step();
    chk("R7 no trip after TMO-1", irq, 0);
    chk("R7 act_out held", act_out, 12'h321);
    drive(1'b1, 12'h222, 1'b1, 12'h222);
    step();
    chk("R7 beat accepted", act_out, 12'h222);
    drive(1'b0, '0, 1'b0, '0);
    for (int n = 0; n < TMO - 1; n++) step();
    chk("R7 idle TMO-1 again", irq, 0);
    step();
    chk("R7 trip after TMO idle", irq, 1);
    chk("R7 trip_code timeout", trip_code, 3);
    chk("R7 act_out dark", act_out, 0);

    // R7: timeout during self-test
    do_clear();
    for (int n = 0; n < TMO; n++) step();
    chk("R7 self-test timeout irq", irq, 1);
    chk("R7 self-test timeout code", trip_code, 3);

    // R10: asynchronous reset mid-cycle in run mode
    do_clear();
    run_st(-1);
    drive(1'b1, 12'h9C4, 1'b1, 12'h9C4);
    step();
    chk("R5 run value", act_out, 12'h9C4);
    #4;
    rst_n = 1'b0;
    #1;
    chk("R10 act_out cleared", act_out, 0);
    chk("R10 tst_sel cleared", tst_sel, 0);
    chk("R10 irq cleared", irq, 0);
    step();
    rst_n = 1'b1;
    drive(1'b0, '0, 1'b0, '0);
    step(); step(); step();
    chk("R10 self-test restarts", tst_sel, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule